// File: doc/BRIEF.md
# Downstream FIFO Overflow Predictor

This block sits in front of a receiver FIFO that gives no fill-level feedback. It works out how full that FIFO probably is from the word counts of recently sent events. Each event's count is held in one of four slots. A slot empties itself after a programmable drain delay, which models the receiver reading the event out. The running total is the sum of the slot counts plus the words already passed for the event in flight.

A data strobe is passed downstream only while that total is below a programmable maximum. If a strobe arrives once the total has reached the limit, the strobe is dropped and a sticky overflow flag is raised. From then on every strobe is blocked, which truncates the event, until a clear pulse arrives. An abort flag is kept alongside the overflow flag. It is masked whenever the ignore-abort setting is high. Two 32-bit status words expose the whole internal state for read-back.

Configuration word layout: bits [19:0] hold the drain delay D in clock ticks, and bits [29:20] hold the 10-bit word maximum M. The customary power-up value of the configuration is 0x3FF00010, which gives M = 1023 and D = 16. The package provides this value as a constant.

Top module: `ovf_predictor`

## Requirements
- R1: After reset, every slot count, the current count, all timer enables, the event index, overflow, the abort flag and strobe_out are zero, so both status words read 0.
- R2: strobe_out follows strobe_in in the same cycle while the total is below M and overflow is clear; each passed strobe raises the current count (status1[9:0]) by one after the clock edge.
- R3: On a cycle with eoe_in high, the current count (plus one if a strobe passes in that same cycle) is written into the slot selected by the event index (status2[23:22]). The current count then returns to 0, the event index advances by one modulo 4, and that slot's timer enable is set.
- R4: A slot loaded at clock edge E keeps its count and enable through edge E+D+1, and reads zero with its enable low after edge E+D+2. A delay of 0 clears the slot after edge E+2.
- R5: status2[21] is 1 exactly when the sum of the four slot counts plus the current count is greater than or equal to M.
- R6: A strobe_in arriving while the total is at or above M is not passed, and the overflow output and status2[20] are set after that clock edge.
- R7: Once set, overflow blocks every strobe, even after the slots have drained, and is cleared only by clear_ovf.
- R8: abort_flag is set by abort_in only while ignore_abort is 0, stays set until clear_ovf, and abort_in has no effect while ignore_abort is 1.
- R9: The fifth event after reset reuses slot 0, overwriting its count and restarting its timer.
- R10: status1 = {2'b0, slot1[9:0], slot0[9:0], current[9:0]}; status2 = {4'b0, enables[3:0] (bit 27 = slot 3), event index[1:0], compare flag, overflow, slot3[9:0], slot2[9:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 30 | [19:0] drain delay in ticks, [29:20] word maximum |
| strobe_in | input | 1 | Data strobe from the event source |
| eoe_in | input | 1 | End-of-event pulse |
| abort_in | input | 1 | Event abort indication |
| ignore_abort | input | 1 | When 1, aborts are masked |
| clear_ovf | input | 1 | Clears the overflow and abort flags |
| strobe_out | output | 1 | Gated strobe toward the receiver FIFO |
| overflow | output | 1 | Sticky truncation flag |
| abort_flag | output | 1 | Sticky, masked abort flag |
| status1 | output | 32 | Read-back word 1 |
| status2 | output | 32 | Read-back word 2 |

## Verification
A slot that fails to clear leaves the total too high forever. The port effect is that strobes are blocked and overflow is raised early, and status2 shows the stale count and its enable two cycles past the programmed delay. A miscounted current count appears in status1 one edge after the strobe. It also moves the cycle at which strobe_out stops following strobe_in. A wrong event index sends the next count to the wrong status field at the very next end-of-event.

// File: rtl/ovfp_pkg.sv
package ovfp_pkg;
   localparam int DLY_LSB = 0;
   localparam int DLY_W   = 20;
   localparam int MAX_LSB = 20;
   localparam int MAX_W   = 10;
   localparam logic [31:0] CFG_POWERUP = 32'h3FF0_0010;

   function automatic logic [31:0] make_cfg(input logic [MAX_W-1:0] mx,
                                            input logic [DLY_W-1:0] dly);
      return {2'b00, mx, dly};
   endfunction
endpackage

// File: rtl/ovfp_slot.sv
// One event-count slot with its drain timer and a registered compare stage.
module ovfp_slot #(
   parameter int CNT_W = 10,
   parameter int TMR_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [TMR_W-1:0] delay,
   output logic [CNT_W-1:0] cnt,
   output logic             en
);
   logic [TMR_W-1:0] tmr;
   logic             hit_q;   // registered result of timer >= delay

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         en    <= 1'b0;
         tmr   <= '0;
         hit_q <= 1'b0;
      end else if (load) begin
         cnt   <= load_val;
         en    <= 1'b1;
         tmr   <= '0;
         hit_q <= 1'b0;
      end else begin
         if (hit_q) begin
            cnt <= '0;
            en  <= 1'b0;
         end
         if (en && !hit_q && (tmr != '1))
            tmr <= tmr + TMR_W'(1);
         hit_q <= en && !hit_q && (tmr >= delay);
      end
   end
endmodule

// File: rtl/ovfp_sum.sv
// Adds the slot counts together.
module ovfp_sum #(
   parameter int CNT_W = 10,
   parameter int NSLOT = 4,
   parameter int SUM_W = CNT_W + 3
) (
   input  logic [NSLOT-1:0][CNT_W-1:0] slot_cnt,
   output logic [SUM_W-1:0]            sum
);
   always_comb begin
      sum = '0;
      for (int i = 0; i < NSLOT; i++)
         sum = sum + SUM_W'(slot_cnt[i]);
   end
endmodule

// File: rtl/ovfp_gate.sv
// Current-event counter, limit compare, strobe gating and sticky flags.
module ovfp_gate #(
   parameter int CNT_W = 10,
   parameter int SUM_W = CNT_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_in,
   input  logic             eoe_in,
   input  logic             abort_in,
   input  logic             ignore_abort,
   input  logic             clear_ovf,
   input  logic [SUM_W-1:0] slot_sum,
   input  logic [CNT_W-1:0] max_cnt,
   output logic             strobe_out,
   output logic [CNT_W-1:0] cur_cnt,
   output logic [CNT_W-1:0] move_val,
   output logic             at_limit,
   output logic             overflow,
   output logic             abort_flag
);
   logic [SUM_W-1:0] total;

   assign total      = slot_sum + SUM_W'(cur_cnt);
   assign at_limit   = total >= SUM_W'(max_cnt);
   assign strobe_out = strobe_in && !at_limit && !overflow;
   assign move_val   = cur_cnt + CNT_W'(strobe_out);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_cnt    <= '0;
         overflow   <= 1'b0;
         abort_flag <= 1'b0;
      end else begin
         if (eoe_in)
            cur_cnt <= '0;
         else if (strobe_out)
            cur_cnt <= cur_cnt + CNT_W'(1);

         if (clear_ovf)
            overflow <= 1'b0;
         else if (strobe_in && at_limit)
            overflow <= 1'b1;

         if (clear_ovf)
            abort_flag <= 1'b0;
         else if (abort_in && !ignore_abort)
            abort_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/ovfp_status.sv
// Packs the read-back words; the layout is defined for four 10-bit slots.
module ovfp_status #(
   parameter int CNT_W = 10,
   parameter int NSLOT = 4,
   parameter int PTR_W = 2
) (
   input  logic [NSLOT-1:0][CNT_W-1:0] slot_cnt,
   input  logic [NSLOT-1:0]            slot_en,
   input  logic [CNT_W-1:0]            cur_cnt,
   input  logic [PTR_W-1:0]            evt_idx,
   input  logic                        at_limit,
   input  logic                        overflow,
   output logic [31:0]                 status1,
   output logic [31:0]                 status2
);
   generate
      if (NSLOT != 4 || CNT_W != 10 || PTR_W != 2) begin : g_bad
         $error("ovfp_status: layout needs NSLOT=4, CNT_W=10");
      end else begin : g_std
         assign status1 = {2'b00, slot_cnt[1], slot_cnt[0], cur_cnt};
         assign status2 = {4'b0000, slot_en, evt_idx, at_limit, overflow,
                           slot_cnt[3], slot_cnt[2]};
      end
   endgenerate
endmodule

// File: rtl/ovf_predictor.sv
module ovf_predictor #(
   parameter int CNT_W = 10,
   parameter int TMR_W = 20,
   parameter int NSLOT = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TMR_W+CNT_W-1:0] cfg_word,
   input  logic                   strobe_in,
   input  logic                   eoe_in,
   input  logic                   abort_in,
   input  logic                   ignore_abort,
   input  logic                   clear_ovf,
   output logic                   strobe_out,
   output logic                   overflow,
   output logic                   abort_flag,
   output logic [31:0]            status1,
   output logic [31:0]            status2
);
   localparam int PTR_W = $clog2(NSLOT);
   localparam int SUM_W = CNT_W + $clog2(NSLOT + 1);

   generate
      if (NSLOT < 2 || (1 << PTR_W) != NSLOT) begin : g_chk_slots
         $error("ovf_predictor: NSLOT must be a power of two");
      end
      if (TMR_W < 1 || CNT_W < 1) begin : g_chk_w
         $error("ovf_predictor: widths must be positive");
      end
   endgenerate

   logic [TMR_W-1:0]            delay;
   logic [CNT_W-1:0]            max_cnt;
   logic [NSLOT-1:0][CNT_W-1:0] slot_cnt;
   logic [NSLOT-1:0]            slot_en;
   logic [SUM_W-1:0]            slot_sum;
   logic [CNT_W-1:0]            cur_cnt;
   logic [CNT_W-1:0]            move_val;
   logic                        at_limit;
   logic [PTR_W-1:0]            evt_idx;

   assign delay   = cfg_word[TMR_W-1:0];
   assign max_cnt = cfg_word[TMR_W+CNT_W-1:TMR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         evt_idx <= '0;
      else if (eoe_in)
         evt_idx <= evt_idx + PTR_W'(1);
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      ovfp_slot #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (eoe_in && (evt_idx == PTR_W'(i))),
         .load_val (move_val),
         .delay    (delay),
         .cnt      (slot_cnt[i]),
         .en       (slot_en[i])
      );
   end

   ovfp_sum #(.CNT_W(CNT_W), .NSLOT(NSLOT), .SUM_W(SUM_W)) u_sum (
      .slot_cnt (slot_cnt),
      .sum      (slot_sum)
   );

   ovfp_gate #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe_in    (strobe_in),
      .eoe_in       (eoe_in),
      .abort_in     (abort_in),
      .ignore_abort (ignore_abort),
      .clear_ovf    (clear_ovf),
      .slot_sum     (slot_sum),
      .max_cnt      (max_cnt),
      .strobe_out   (strobe_out),
      .cur_cnt      (cur_cnt),
      .move_val     (move_val),
      .at_limit     (at_limit),
      .overflow     (overflow),
      .abort_flag   (abort_flag)
   );

   ovfp_status #(.CNT_W(CNT_W), .NSLOT(NSLOT), .PTR_W(PTR_W)) u_status (
      .slot_cnt (slot_cnt),
      .slot_en  (slot_en),
      .cur_cnt  (cur_cnt),
      .evt_idx  (evt_idx),
      .at_limit (at_limit),
      .overflow (overflow),
      .status1  (status1),
      .status2  (status2)
   );
endmodule

// File: rtl/ovfp_checker.sv
module ovfp_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        strobe_in,
   input logic        strobe_out,
   input logic        eoe_in,
   input logic        abort_in,
   input logic        ignore_abort,
   input logic        clear_ovf,
   input logic        overflow,
   input logic        abort_flag,
   input logic [31:0] status1,
   input logic [31:0] status2
);
   // R2: a passed strobe advances the current count by one
   a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_out && !eoe_in) |=> status1[9:0] == $past(status1[9:0]) + 10'd1);

   // R3: each end-of-event advances the event index
   a_r3_evt_idx: assert property (@(posedge clk) disable iff (!rst_n)
      eoe_in |=> status2[23:22] == $past(status2[23:22]) + 2'd1);

   // R5: no strobe passes while the compare flag is set
   a_r5_no_pass_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      status2[21] |-> !strobe_out);

   // R6: a strobe at the limit raises overflow
   a_r6_set_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_in && status2[21] && !clear_ovf) |=> overflow);

   // R7: overflow blocks strobes and persists until cleared
   a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> !strobe_out);
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clear_ovf) |=> overflow);

   // R8: abort masked by ignore_abort
   a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (!abort_flag && ignore_abort) |=> !abort_flag);
   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_in && !ignore_abort && !clear_ovf) |=> abort_flag);

   // R10: unused status bits stay zero
   a_r10_pad: assert property (@(posedge clk) disable iff (!rst_n)
      status1[31:30] == 2'b00 && status2[31:28] == 4'b0000);
endmodule

bind ovf_predictor ovfp_checker u_ovfp_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .strobe_in    (strobe_in),
   .strobe_out   (strobe_out),
   .eoe_in       (eoe_in),
   .abort_in     (abort_in),
   .ignore_abort (ignore_abort),
   .clear_ovf    (clear_ovf),
   .overflow     (overflow),
   .abort_flag   (abort_flag),
   .status1      (status1),
   .status2      (status2)
);

// File: tb/tb_ovf_predictor.sv
module tb_ovf_predictor;
   import ovfp_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [29:0] cfg_word;
   logic        strobe_in, eoe_in, abort_in, ignore_abort, clear_ovf;
   logic        strobe_out, overflow, abort_flag;
   logic [31:0] status1, status2;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   ovf_predictor dut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
      .strobe_in(strobe_in), .eoe_in(eoe_in), .abort_in(abort_in),
      .ignore_abort(ignore_abort), .clear_ovf(clear_ovf),
      .strobe_out(strobe_out), .overflow(overflow), .abort_flag(abort_flag),
      .status1(status1), .status2(status2)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [31:0] cfg);
      cfg_word = cfg[29:0];
      strobe_in = 0; eoe_in = 0; abort_in = 0; clear_ovf = 0; ignore_abort = 0;
      rst_n = 0;
      tick(); tick();
      rst_n = 1;
      tick();
   endtask

   task automatic send_words(input int n);
      for (int i = 0; i < n; i++) begin
         strobe_in = 1;
         tick();
      end
      strobe_in = 0;
   endtask

   task automatic end_event();
      eoe_in = 1;
      tick();
      eoe_in = 0;
   endtask

   task automatic t_reset();
      do_reset(CFG_POWERUP);
      chk("R1", "status1", status1, 32'h0);
      chk("R1", "status2", status2, 32'h0);
      chk("R1", "overflow", {31'b0, overflow}, 32'h0);
      chk("R1", "abort_flag", {31'b0, abort_flag}, 32'h0);
      chk("R1", "strobe_out", {31'b0, strobe_out}, 32'h0);
   endtask

   task automatic t_counting();
      do_reset(make_cfg(10'd1023, 20'd1000));
      strobe_in = 1; #1;
      chk("R2", "strobe_out passes", {31'b0, strobe_out}, 32'h1);
      @(negedge clk); strobe_in = 0;
      send_words(4);
      chk("R2", "current count", {22'b0, status1[9:0]}, 32'd5);
      strobe_in = 1; eoe_in = 1;
      tick();
      strobe_in = 0; eoe_in = 0;
      chk("R3", "slot0 incl. same-cycle word", {22'b0, status1[19:10]}, 32'd6);
      chk("R3", "current cleared", {22'b0, status1[9:0]}, 32'd0);
      chk("R3", "event index", {30'b0, status2[23:22]}, 32'd1);
      chk("R10", "enables", {28'b0, status2[27:24]}, 32'h1);
      send_words(3); end_event();
      chk("R10", "slot1 field", {22'b0, status1[29:20]}, 32'd3);
      send_words(2); end_event();
      chk("R10", "slot2 field", {22'b0, status2[9:0]}, 32'd2);
      send_words(4); end_event();
      chk("R10", "slot3 field", {22'b0, status2[19:10]}, 32'd4);
      chk("R10", "all enables", {28'b0, status2[27:24]}, 32'hF);
      chk("R3", "index wraps to 0", {30'b0, status2[23:22]}, 32'd0);
      send_words(1); end_event();
      chk("R9", "slot0 overwritten", {22'b0, status1[19:10]}, 32'd1);
      chk("R9", "index after fifth", {30'b0, status2[23:22]}, 32'd1);
   endtask

   task automatic t_timer();
      do_reset(make_cfg(10'd1023, 20'd5));
      send_words(2); end_event();
      repeat (6) tick();
      chk("R4", "slot0 held at D+1", {22'b0, status1[19:10]}, 32'd2);
      chk("R4", "enable held at D+1", {31'b0, status2[24]}, 32'h1);
      tick();
      chk("R4", "slot0 cleared at D+2", {22'b0, status1[19:10]}, 32'd0);
      chk("R4", "enable dropped", {31'b0, status2[24]}, 32'h0);
      cfg_word = make_cfg(10'd1023, 20'd0);
      send_words(3); end_event();
      tick();
      chk("R4", "delay0 held at 1", {22'b0, status1[29:20]}, 32'd3);
      tick();
      chk("R4", "delay0 cleared at 2", {22'b0, status1[29:20]}, 32'd0);
   endtask

   task automatic t_limit();
      do_reset(make_cfg(10'd6, 20'd100));
      send_words(4); end_event();
      send_words(1);
      chk("R5", "flag below max", {31'b0, status2[21]}, 32'h0);
      strobe_in = 1; #1;
      chk("R2", "strobe passes at total 5", {31'b0, strobe_out}, 32'h1);
      @(negedge clk); strobe_in = 0;
      chk("R5", "flag at max", {31'b0, status2[21]}, 32'h1);
      strobe_in = 1; #1;
      chk("R6", "strobe blocked", {31'b0, strobe_out}, 32'h0);
      @(negedge clk); strobe_in = 0;
      chk("R6", "overflow set", {31'b0, overflow}, 32'h1);
      chk("R6", "status overflow bit", {31'b0, status2[20]}, 32'h1);
      chk("R6", "count frozen", {22'b0, status1[9:0]}, 32'd2);
   endtask

   task automatic t_sticky();
      do_reset(make_cfg(10'd4, 20'd3));
      send_words(4);
      strobe_in = 1; tick(); strobe_in = 0;
      chk("R6", "overflow at 4", {31'b0, overflow}, 32'h1);
      end_event();
      repeat (5) tick();
      chk("R7", "slots drained", {31'b0, status2[21]}, 32'h0);
      chk("R7", "overflow persists", {31'b0, overflow}, 32'h1);
      strobe_in = 1; #1;
      chk("R7", "strobe still blocked", {31'b0, strobe_out}, 32'h0);
      @(negedge clk); strobe_in = 0;
      chk("R7", "no count while blocked", {22'b0, status1[9:0]}, 32'd0);
      clear_ovf = 1; tick(); clear_ovf = 0;
      chk("R7", "overflow cleared", {31'b0, overflow}, 32'h0);
      strobe_in = 1; #1;
      chk("R7", "strobe passes after clear", {31'b0, strobe_out}, 32'h1);
      @(negedge clk); strobe_in = 0;
   endtask

   task automatic t_abort();
      do_reset(CFG_POWERUP);
      ignore_abort = 1; abort_in = 1; tick(); abort_in = 0;
      chk("R8", "abort ignored", {31'b0, abort_flag}, 32'h0);
      ignore_abort = 0; abort_in = 1; tick(); abort_in = 0;
      chk("R8", "abort set", {31'b0, abort_flag}, 32'h1);
      tick(); tick();
      chk("R8", "abort sticky", {31'b0, abort_flag}, 32'h1);
      clear_ovf = 1; tick(); clear_ovf = 0;
      chk("R8", "abort cleared", {31'b0, abort_flag}, 32'h0);
   endtask

   initial begin
      t_reset();
      t_counting();
      t_timer();
      t_limit();
      t_sticky();
      t_abort();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule